// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block collects interrupt requests into a sixteen-level pending register and always presents the most urgent request that is both pending and allowed through. Level 0 is the most urgent. The reported vector is the lowest-numbered pending level that passes the mask and the global enable. The power-down line owns level 0 and is never blocked.

The six user lines occupy levels 1 to 6. The two I/O-level lines occupy levels 7 and 8. An internal set port can raise any of the sixteen levels directly. One configuration bit selects rising-edge or high-level detection for the power-down and user lines. The I/O-level lines are always level sensitive.

Every external line passes through a two-flop synchronizer. A request that is seen sets a sticky pending bit. That bit is cleared only when the surrounding processor acknowledges the level currently on the vector output. A separate console request input is synchronized and passed on as a go flag only while the processor signals that the current instruction has completed.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `irq_req` is 0, `irq_vec` is 0, `con_go` is 0, every mask bit is 0 (unmasked) and no level is pending.
- R2: When several levels are pending and eligible, `irq_vec` shows the lowest-numbered one and `irq_req` is 1.
- R3: A mask bit at 1 keeps its level off the outputs, but the level is still recorded as pending. Clearing the mask bit later exposes it.
- R4: With `glob_en` low, no level other than 0 can raise `irq_req`.
- R5: A pending level 0 (power-down) is reported whatever the values of `glob_en` and its mask bit.
- R6: With `edge_mode` = 1, a rising edge on the power-down line or a user line sets its level pending on the third clock edge after the input changes. The bit stays set after the line falls, and it stays clear after acknowledge even while the line is held high.
- R7: With `edge_mode` = 0, a high power-down or user line keeps its level pending, so an acknowledge has no effect while the line is high. Once the low level has passed the synchronizer, an acknowledge clears the bit.
- R8: The I/O-level lines (`iol_in[0]` is level 7, `iol_in[1]` is level 8) are level sensitive whatever `edge_mode` holds.
- R9: A 1 on `int_set[k]` makes level k pending at the next clock edge.
- R10: `ack` while `irq_req` is 1 clears only the pending bit of the level shown on `irq_vec`. If the same level is being set in that cycle, the set wins.
- R11: `con_go` is 1 exactly when the synchronized `con_req_n` is low (two clock edges after the input changes) and `instr_done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn_in | input | 1 | Power-down request, level 0 |
| usr_in | input | 6 | User requests, bit i is level i+1 |
| iol_in | input | 2 | I/O-level requests, levels 7 and 8, active high |
| int_set | input | 16 | Internal one-cycle set strobes, one per level |
| edge_mode | input | 1 | 1 = rising edge, 0 = high level, for power-down and user lines |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 16 | New mask value, 1 blocks a level |
| glob_en | input | 1 | Global enable for levels 1 to 15 |
| ack | input | 1 | Acknowledge: clears the currently reported level |
| con_req_n | input | 1 | Console request, active low |
| instr_done | input | 1 | Current instruction has completed |
| irq_req | output | 1 | An eligible request is pending |
| irq_vec | output | 4 | Level number of the reported request |
| con_go | output | 1 | Console request may be taken now |

## Verification
External lines reach the pending register on the third rising edge after they change. The bench therefore sees the result at the falling edge after that third edge, and it checks the falling edge before as well, to confirm nothing shows early. Internal set strobes, mask writes and acknowledges are driven at a falling edge and take effect at the next rising edge, so their results are checked one falling edge later. `glob_en` and `instr_done` act combinationally and are checked at the same falling edge at which they change. `con_go` follows `con_req_n` after two rising edges, and the bench checks both the intermediate edge and the final one.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NLVL = 16,
  parameter int NUSR = 6,
  parameter int NIOL = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwrdn_in,
  input  logic [NUSR-1:0] usr_in,
  input  logic [NIOL-1:0] iol_in,
  input  logic [NLVL-1:0] int_set,
  input  logic            edge_mode,
  input  logic            mask_we,
  input  logic [NLVL-1:0] mask_wdata,
  input  logic            glob_en,
  input  logic            ack,
  input  logic            con_req_n,
  input  logic            instr_done,
  output logic            irq_req,
  output logic [$clog2(NLVL)-1:0] irq_vec,
  output logic            con_go
);
  localparam int NLINE = 1 + NUSR + NIOL;
  localparam int NEDGE = 1 + NUSR;
  localparam int VW    = $clog2(NLVL);

  logic [NLINE-1:0] s1, s2, s3, rise, hw_set;
  logic [NLVL-1:0]  pend_q, mask_q, elig, clr, set_vec;
  logic             c1, c2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= {iol_in, usr_in, pwrdn_in};
      s2 <= s1;
      s3 <= s2;
    end

  assign rise = s2 & ~s3;

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    if (g < NEDGE) begin : g_sel
      assign hw_set[g] = edge_mode ? rise[g] : s2[g];
    end else begin : g_lvl
      assign hw_set[g] = s2[g];
    end
  end

  assign set_vec = int_set | {{(NLVL-NLINE){1'b0}}, hw_set};
  assign elig    = pend_q & ((glob_en ? ~mask_q : '0) | NLVL'(1));

  always_comb begin
    irq_vec = '0;
    for (int i = NLVL-1; i >= 0; i--)
      if (elig[i]) irq_vec = VW'(i);
  end

  assign irq_req = |elig;
  assign clr     = (irq_req && ack) ? (NLVL'(1) << irq_vec) : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clr) | set_vec;
      if (mask_we) mask_q <= mask_wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      c1 <= 1'b1; c2 <= 1'b1;
    end else begin
      c1 <= con_req_n;
      c2 <= c1;
    end

  assign con_go = ~c2 & instr_done;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int NLVL = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            glob_en,
  input logic            ack,
  input logic            instr_done,
  input logic [NLVL-1:0] int_set,
  input logic [NLVL-1:0] pend,
  input logic [NLVL-1:0] mask,
  input logic            irq_req,
  input logic [$clog2(NLVL)-1:0] irq_vec,
  input logic            con_go
);
  a_r2_vec_is_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> pend[irq_vec] && (irq_vec == 0 || (glob_en && !mask[irq_vec])));

  a_r5_pwrdn_wins: assert property (@(posedge clk) disable iff (!rst_n)
    pend[0] |-> irq_req && irq_vec == 0);

  a_r4_disabled_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!glob_en && irq_req) |-> irq_vec == 0);

  a_r9_internal_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|int_set) |=> (pend & $past(int_set)) == $past(int_set));

  a_r10_clear_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(pend) & ~pend)) |-> $past(ack && irq_req));

  a_r11_con_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    con_go |-> instr_done);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NLVL(NLVL)) chk_i (
  .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .ack(ack),
  .instr_done(instr_done), .int_set(int_set), .pend(pend_q), .mask(mask_q),
  .irq_req(irq_req), .irq_vec(irq_vec), .con_go(con_go)
);

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
  logic clk = 0, rst_n = 0;
  logic pwrdn_in = 0, edge_mode = 1, mask_we = 0, glob_en = 1, ack = 0;
  logic con_req_n = 1, instr_done = 0;
  logic [5:0] usr_in = '0;
  logic [1:0] iol_in = '0;
  logic [15:0] int_set = '0, mask_wdata = '0;
  logic irq_req, con_go;
  logic [3:0] irq_vec;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  irq_prio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .pwrdn_in(pwrdn_in), .usr_in(usr_in), .iol_in(iol_in),
    .int_set(int_set), .edge_mode(edge_mode), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .glob_en(glob_en), .ack(ack), .con_req_n(con_req_n), .instr_done(instr_done),
    .irq_req(irq_req), .irq_vec(irq_vec), .con_go(con_go)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input bit er, input int ev);
    int a = irq_req ? int'(irq_vec) : -1;
    int e = er ? ev : -1;
    chk(a == e, tag, a, e);
  endtask

  function automatic int exp_vec(input logic [15:0] p, input logic [15:0] m, input bit en);
    if (p[0]) return 0;
    if (!en) return -1;
    for (int i = 1; i < 16; i++) if (p[i] && !m[i]) return i;
    return -1;
  endfunction

  task automatic clear_all();
    mask_we = 1; mask_wdata = '0; glob_en = 1;
    step(1);
    mask_we = 0; ack = 1;
    step(18);
    ack = 0;
    step(1);
  endtask

  initial begin
    #(5ns * 20000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    chk(irq_req == 0 && irq_vec == 0 && con_go == 0, "R1 reset outputs", {irq_req, irq_vec, con_go}, 0);
    int_set = 16'h0010; step(1); int_set = '0;
    chk_out("R1 mask reset clear", 1, 4);
    clear_all();

    for (int i = 0; i < 64; i++) begin
      logic [15:0] pat, m;
      int ev;
      pat = 16'((i * 40503) ^ (i << 7) ^ 16'h2a40) & 16'hfffe;
      if (i % 8 == 0) pat[0] = 1;
      if (pat == 0) pat = 16'h8000;
      m = {pat[4:0], pat[15:5]} ^ 16'(i * 3);
      clear_all();
      int_set = pat; mask_we = 1; mask_wdata = m;
      step(1);
      int_set = '0; mask_we = 0;
      glob_en = 1;
      ev = exp_vec(pat, m, 1);
      chk_out("R2 R9 sweep enabled", ev >= 0, ev);
      glob_en = 0;
      #1;
      ev = exp_vec(pat, m, 0);
      chk_out("R4 R5 sweep disabled", ev >= 0, ev);
      glob_en = 1;
    end
    clear_all();

    int_set = 16'h0010; mask_we = 1; mask_wdata = 16'h0010;
    step(1); int_set = '0; mask_we = 0;
    chk_out("R3 masked hidden", 0, 0);
    mask_we = 1; mask_wdata = '0; step(1); mask_we = 0;
    chk_out("R3 unmask exposes", 1, 4);
    clear_all();

    int_set = 16'h0208; step(1); int_set = '0;
    chk_out("R2 two pending", 1, 3);
    ack = 1; step(1); ack = 0;
    chk_out("R10 only reported cleared", 1, 9);
    clear_all();

    edge_mode = 1;
    usr_in[2] = 1;
    step(2); chk_out("R6 not before third edge", 0, 0);
    step(1); chk_out("R6 edge captured", 1, 3);
    ack = 1; step(1); ack = 0;
    step(3); chk_out("R6 held line no refire", 0, 0);
    usr_in[2] = 0; step(3);
    usr_in[4] = 1; step(1); usr_in[4] = 0;
    step(2); chk_out("R6 pulse captured", 1, 5);
    step(10); chk_out("R6 sticky", 1, 5);
    ack = 1; step(1); ack = 0;
    chk_out("R6 ack clears", 0, 0);
    clear_all();

    edge_mode = 0;
    usr_in[0] = 1;
    step(3); chk_out("R7 level captured", 1, 1);
    ack = 1; step(1); ack = 0;
    chk_out("R7 ack ignored while high", 1, 1);
    usr_in[0] = 0; step(4);
    chk_out("R7 sticky after drop", 1, 1);
    ack = 1; step(1); ack = 0;
    chk_out("R7 ack clears after drop", 0, 0);
    clear_all();

    edge_mode = 1;
    iol_in[0] = 1;
    step(3); chk_out("R8 io line captured", 1, 7);
    ack = 1; step(1); ack = 0;
    chk_out("R8 io level in edge mode", 1, 7);
    iol_in[0] = 0; step(4);
    ack = 1; step(1); ack = 0;
    chk_out("R8 io cleared", 0, 0);
    clear_all();

    mask_we = 1; mask_wdata = 16'hffff; step(1); mask_we = 0;
    glob_en = 0;
    pwrdn_in = 1; step(3);
    chk_out("R5 pwrdn through mask and disable", 1, 0);
    pwrdn_in = 0;
    ack = 1; step(1); ack = 0;
    chk_out("R5 pwrdn acked", 0, 0);
    clear_all();

    edge_mode = 1;
    pwrdn_in = 1; usr_in = 6'h3f;
    step(3);
    for (int k = 0; k <= 6; k++) begin
      chk_out("R2 simultaneous order", 1, k);
      ack = 1; step(1); ack = 0;
    end
    chk_out("R2 all served", 0, 0);
    pwrdn_in = 0; usr_in = '0;
    clear_all();

    con_req_n = 0; instr_done = 0;
    step(1); #1;
    instr_done = 1; #1;
    chk(con_go == 0, "R11 one edge not enough", con_go, 0);
    instr_done = 0;
    step(1);
    chk(con_go == 0, "R11 waits for done", con_go, 0);
    instr_done = 1; #1;
    chk(con_go == 1, "R11 go", con_go, 1);
    con_req_n = 1; step(1);
    chk(con_go == 1, "R11 release lag", con_go, 1);
    step(1);
    chk(con_go == 0, "R11 released", con_go, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule